// File: doc/BRIEF.md
# Dual Pixel Queue and Layer Mixer

This block sits between a tile fetcher and a display driver. It keeps two short pixel queues, one for the background layer and one for the object layer. On every enabled dot it moves both queue heads forward together. Background row slices arrive as two bitplane bytes and are only taken when the background queue has drained.

Object row slices are not appended. They are merged into the object queue, so an object drawn earlier on the line keeps its opaque pixels over later ones. A short priority chain picks either the background head or the object head. The chosen 2-bit colour index is then mapped through a 4-field palette register to a 2-bit shade, which comes out registered with a valid strobe.

A line-start pulse empties both queues and restarts the per-line pixel count. A stall input freezes both queues while an object fetch is in progress.

Top module: `pixmix_top`

## Requirements
- R1: After reset, and on the cycle after `lineStart`, both queues are empty, `bgReady` is 1, `shadeValid` is 0, and the line pixel count restarts at zero. `lineStart` overrides every other input in its cycle.
- R2: A background push loads 8 pixels only when the background queue is empty (`bgReady`=1). A push while the queue is not empty is ignored. Pixel i (0 = first out) takes colour index {`bgPlaneHi`[7-i], `bgPlaneLo`[7-i]}.
- R3: On a clock with `dotEn`=1, the background queue not empty and no stall or object push, both queues shift by one pixel. The resulting shade appears on `shadeOut` with `shadeValid`=1 after that same edge. On every other clock, `shadeValid` is 0.
- R4: While `stall`=1 or `dotEn`=0, neither queue shifts, and no shade is produced.
- R5: An object push overwrites an object-queue entry only where that entry's colour index is 0. The overwrite replaces the index, the palette bit and the priority bit. Pixel i uses the same bit order as in R2.
- R6: Object-queue slots vacated by shifting are refilled with transparent pixels (index 0, palette 0, priority 0). A later object push can therefore fill them.
- R7: Selection chain. When `layerEn`[0]=0, the background index is treated as 0. When `layerEn`[1]=0, the background is chosen. When the object priority bit is 1 and the background index is nonzero, the background is chosen. When the object index is 0, the background is chosen. Otherwise the object is chosen.
- R8: Index n selects bits [2n+1:2n] of the palette register. Background pixels use `palBg`. Object pixels use `palObj0` when their palette bit is 0 and `palObj1` when it is 1.
- R9: At most 160 shades are produced between line starts.
- R10: A cycle with `objPushValid`=1 does not shift the queues, even when `dotEn`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lineStart | input | 1 | Start of the pixel-transfer phase; clears the queues and the line count |
| dotEn | input | 1 | Dot clock enable |
| stall | input | 1 | Freezes both queues during an object fetch |
| bgPushValid | input | 1 | Background slice push request |
| bgPlaneLo | input | 8 | Background low bitplane; bit 7 is the first pixel |
| bgPlaneHi | input | 8 | Background high bitplane |
| bgReady | output | 1 | Background queue empty; a push will be taken |
| objPushValid | input | 1 | Object slice merge request |
| objPlaneLo | input | 8 | Object low bitplane |
| objPlaneHi | input | 8 | Object high bitplane |
| objPalSel | input | 1 | Object palette select bit |
| objBehindBg | input | 1 | Object priority bit (yields to a nonzero background) |
| layerEn | input | 2 | Bit 0 enables the background layer; bit 1 enables the object layer |
| palBg | input | 8 | Background palette, four 2-bit fields |
| palObj0 | input | 8 | Object palette 0 |
| palObj1 | input | 8 | Object palette 1 |
| shadeOut | output | 2 | Output shade |
| shadeValid | output | 1 | Strobe for `shadeOut` |

## Verification
The assertions assume that `objPushValid` comes only while the fetcher owns the queues. They also assume that palette and enable inputs are steady for the dot they feed. The stimulus never raises `objPushValid` and `lineStart` in the same cycle. It holds the palettes constant within each sweep point. The mixer sweep walks every combination of background index, object index, object priority, palette bit and both layer enables.

// File: rtl/pixmix_pkg.sv
package pixmix_pkg;

  typedef struct packed {
    logic [1:0] idx;
    logic       pal;
    logic       prio;
  } pixel_t;

  typedef struct packed {
    logic clearAll;
    logic shift;
    logic bgLoad;
    logic objMerge;
  } strobe_t;

  localparam pixel_t PIX_CLEAR = '0;

endpackage

// File: rtl/pixmix_ctrl.sv
module pixmix_ctrl
  import pixmix_pkg::*;
#(
  parameter int LINE_PIXELS = 160
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    lineStart,
  input  logic    dotEn,
  input  logic    stall,
  input  logic    bgPushValid,
  input  logic    objPushValid,
  input  logic    bgEmpty,
  output strobe_t strobes
);

  localparam int PIXC_W = $clog2(LINE_PIXELS + 1);

  logic [PIXC_W-1:0] pixCount;
  logic              lineDone;

  assign lineDone = (pixCount == PIXC_W'(LINE_PIXELS));

  always_comb begin
    strobes.clearAll = lineStart;
    strobes.shift    = dotEn && !stall && !objPushValid && !bgEmpty && !lineDone && !lineStart;
    strobes.bgLoad   = bgPushValid && bgEmpty && !lineStart;
    strobes.objMerge = objPushValid && !lineStart;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pixCount <= '0;
    end else if (lineStart) begin
      pixCount <= '0;
    end else if (strobes.shift) begin
      pixCount <= pixCount + 1'b1;
    end
  end

  AST_LINE_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    pixCount <= PIXC_W'(LINE_PIXELS)); // R9

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !$past(lineStart) |-> (pixCount == $past(pixCount)) || (pixCount == $past(pixCount) + 1'b1)); // R3

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (stall && !lineStart) |=> $stable(pixCount)); // R4

  AST_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    lineStart |=> pixCount == '0); // R1

endmodule

// File: rtl/pixmix_select.sv
module pixmix_select
  import pixmix_pkg::*;
(
  input  pixel_t     bgPix,
  input  pixel_t     objPix,
  input  logic [1:0] layerEn,
  input  logic [7:0] palBg,
  input  logic [7:0] palObj0,
  input  logic [7:0] palObj1,
  output logic [1:0] shade
);

  logic [1:0] bgIdxEff;
  logic       pickObj;
  logic [7:0] objPal;

  always_comb begin
    bgIdxEff = layerEn[0] ? bgPix.idx : 2'd0;
    pickObj  = 1'b1;
    if (!layerEn[1])                        pickObj = 1'b0;
    else if (objPix.prio && bgIdxEff != 0)  pickObj = 1'b0;
    else if (objPix.idx == 2'd0)            pickObj = 1'b0;
    objPal = objPix.pal ? palObj1 : palObj0;
    shade  = pickObj ? objPal[2*objPix.idx +: 2] : palBg[2*bgIdxEff +: 2];
  end

endmodule

// File: rtl/pixmix_datapath.sv
module pixmix_datapath
  import pixmix_pkg::*;
#(
  parameter int SLICE_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strobes,
  input  logic [SLICE_W-1:0] bgPlaneLo,
  input  logic [SLICE_W-1:0] bgPlaneHi,
  input  logic [SLICE_W-1:0] objPlaneLo,
  input  logic [SLICE_W-1:0] objPlaneHi,
  input  logic               objPalSel,
  input  logic               objBehindBg,
  input  logic [1:0]         layerEn,
  input  logic [7:0]         palBg,
  input  logic [7:0]         palObj0,
  input  logic [7:0]         palObj1,
  output logic               bgEmpty,
  output logic [1:0]         shadeOut,
  output logic               shadeValid
);

  localparam int CNT_W = $clog2(SLICE_W + 1);

  pixel_t           bgQ    [SLICE_W];
  pixel_t           objQ   [SLICE_W];
  pixel_t           bgNew  [SLICE_W];
  pixel_t           objNew [SLICE_W];
  logic [CNT_W-1:0] bgCount;
  logic [1:0]       selShade;

  // Slice decode: first pixel out comes from the top bit of each plane.
  for (genvar g = 0; g < SLICE_W; g++) begin : g_decode
    assign bgNew[g]  = '{idx: {bgPlaneHi[SLICE_W-1-g], bgPlaneLo[SLICE_W-1-g]},
                         pal: 1'b0, prio: 1'b0};
    assign objNew[g] = '{idx: {objPlaneHi[SLICE_W-1-g], objPlaneLo[SLICE_W-1-g]},
                         pal: objPalSel, prio: objBehindBg};
  end

  assign bgEmpty = (bgCount == '0);

  pixmix_select uSelect (
    .bgPix   (bgQ[0]),
    .objPix  (objQ[0]),
    .layerEn (layerEn),
    .palBg   (palBg),
    .palObj0 (palObj0),
    .palObj1 (palObj1),
    .shade   (selShade)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SLICE_W; i++) begin
        bgQ[i]  <= PIX_CLEAR;
        objQ[i] <= PIX_CLEAR;
      end
      bgCount    <= '0;
      shadeOut   <= '0;
      shadeValid <= 1'b0;
    end else if (strobes.clearAll) begin
      for (int i = 0; i < SLICE_W; i++) begin
        bgQ[i]  <= PIX_CLEAR;
        objQ[i] <= PIX_CLEAR;
      end
      bgCount    <= '0;
      shadeOut   <= '0;
      shadeValid <= 1'b0;
    end else begin
      shadeValid <= strobes.shift;
      if (strobes.shift) begin
        shadeOut <= selShade;
        for (int i = 0; i < SLICE_W - 1; i++) begin
          bgQ[i]  <= bgQ[i+1];
          objQ[i] <= objQ[i+1];
        end
        bgQ[SLICE_W-1]  <= PIX_CLEAR;
        objQ[SLICE_W-1] <= PIX_CLEAR;
        bgCount <= bgCount - 1'b1;
      end
      if (strobes.bgLoad) begin
        for (int i = 0; i < SLICE_W; i++) bgQ[i] <= bgNew[i];
        bgCount <= CNT_W'(SLICE_W);
      end
      if (strobes.objMerge) begin
        for (int i = 0; i < SLICE_W; i++) begin
          if (objQ[i].idx == 2'd0) objQ[i] <= objNew[i];
        end
      end
    end
  end

  AST_BG_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    bgCount <= CNT_W'(SLICE_W)); // R2

  AST_SHIFT_NEEDS_PIXELS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.shift |-> bgCount != '0); // R3

  AST_VALID_FROM_QUEUE: assert property (@(posedge clk) disable iff (!rstN)
    shadeValid |-> $past(bgCount) != '0); // R3

  AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clearAll |=> (bgCount == '0) && !shadeValid); // R1

  AST_LOAD_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.bgLoad && !strobes.clearAll) |=> bgCount == CNT_W'(SLICE_W)); // R2

  AST_OBJ_KEEP_OPAQUE: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.objMerge && !strobes.shift && objQ[0].idx != 2'd0) |=> $stable(objQ[0])); // R5

endmodule

// File: rtl/pixmix_top.sv
module pixmix_top
  import pixmix_pkg::*;
#(
  parameter int SLICE_W     = 8,
  parameter int LINE_PIXELS = 160
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               lineStart,
  input  logic               dotEn,
  input  logic               stall,
  input  logic               bgPushValid,
  input  logic [SLICE_W-1:0] bgPlaneLo,
  input  logic [SLICE_W-1:0] bgPlaneHi,
  output logic               bgReady,
  input  logic               objPushValid,
  input  logic [SLICE_W-1:0] objPlaneLo,
  input  logic [SLICE_W-1:0] objPlaneHi,
  input  logic               objPalSel,
  input  logic               objBehindBg,
  input  logic [1:0]         layerEn,
  input  logic [7:0]         palBg,
  input  logic [7:0]         palObj0,
  input  logic [7:0]         palObj1,
  output logic [1:0]         shadeOut,
  output logic               shadeValid
);

  strobe_t strobes;
  logic    bgEmpty;

  assign bgReady = bgEmpty;

  pixmix_ctrl #(.LINE_PIXELS(LINE_PIXELS)) uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .lineStart    (lineStart),
    .dotEn        (dotEn),
    .stall        (stall),
    .bgPushValid  (bgPushValid),
    .objPushValid (objPushValid),
    .bgEmpty      (bgEmpty),
    .strobes      (strobes)
  );

  pixmix_datapath #(.SLICE_W(SLICE_W)) uData (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .bgPlaneLo   (bgPlaneLo),
    .bgPlaneHi   (bgPlaneHi),
    .objPlaneLo  (objPlaneLo),
    .objPlaneHi  (objPlaneHi),
    .objPalSel   (objPalSel),
    .objBehindBg (objBehindBg),
    .layerEn     (layerEn),
    .palBg       (palBg),
    .palObj0     (palObj0),
    .palObj1     (palObj1),
    .bgEmpty     (bgEmpty),
    .shadeOut    (shadeOut),
    .shadeValid  (shadeValid)
  );

endmodule

// File: tb/pixmix_top_test.sv
module pixmix_top_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       lineStart = 1'b0, dotEn = 1'b0, stall = 1'b0;
  logic       bgPushValid = 1'b0, objPushValid = 1'b0;
  logic [7:0] bgPlaneLo = '0, bgPlaneHi = '0, objPlaneLo = '0, objPlaneHi = '0;
  logic       objPalSel = 1'b0, objBehindBg = 1'b0;
  logic [1:0] layerEn = 2'b11;
  logic [7:0] palBg = 8'hE4, palObj0 = 8'h1B, palObj1 = 8'h4E;
  logic       bgReady, shadeValid;
  logic [1:0] shadeOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  pixmix_top uut (.*);

  always #10 clk = ~clk;

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [1:0] fld(input logic [7:0] p, input logic [1:0] n);
    return p[2*n +: 2];
  endfunction

  // Expected shade from the selection chain and palette mapping.
  function automatic logic [1:0] expShade(input logic [1:0] bIdx, input logic [1:0] oIdx,
                                          input logic oPrio, input logic oPal, input logic [1:0] en);
    logic [1:0] b;
    b = en[0] ? bIdx : 2'd0;
    if (!en[1] || (oPrio && b != 0) || oIdx == 0) return fld(palBg, b);
    return fld(oPal ? palObj1 : palObj0, oIdx);
  endfunction

  // pix[2i+1:2i] is pixel i; produce the two bitplanes.
  task automatic setPlanes(input logic [15:0] pix, output logic [7:0] lo, output logic [7:0] hi);
    for (int i = 0; i < 8; i++) begin
      lo[7-i] = pix[2*i];
      hi[7-i] = pix[2*i+1];
    end
  endtask

  task automatic pushBg(input logic [15:0] pix);
    setPlanes(pix, bgPlaneLo, bgPlaneHi);
    bgPushValid = 1'b1;
    tick();
    bgPushValid = 1'b0;
  endtask

  task automatic pushObj(input logic [15:0] pix, input logic pal, input logic prio);
    setPlanes(pix, objPlaneLo, objPlaneHi);
    objPalSel = pal;
    objBehindBg = prio;
    objPushValid = 1'b1;
    tick();
    objPushValid = 1'b0;
  endtask

  task automatic startLine();
    lineStart = 1'b1;
    tick();
    lineStart = 1'b0;
  endtask

  task automatic shiftExpect(input logic [1:0] exp, input string req);
    dotEn = 1'b1;
    tick();
    dotEn = 1'b0;
    check(shadeValid === 1'b1, req, shadeValid, 1);
    check(shadeOut === exp, req, shadeOut, exp);
  endtask

  initial begin
    logic [15:0] rowA, rowB;
    int validCount;
    repeat (3) tick();
    rstN = 1'b1;
    tick();

    // R1 reset state
    check(bgReady === 1'b1, "R1 reset ready", bgReady, 1);
    check(shadeValid === 1'b0, "R1 reset valid", shadeValid, 0);

    // R8 palette sweep with a 0,1,2,3 repeating background row
    for (int k = 0; k < 16; k++) begin
      palBg = 8'((k * 8'h3B) ^ 8'hA5);
      startLine();
      pushBg(16'hE4E4);
      for (int i = 0; i < 8; i++) shiftExpect(fld(palBg, 2'(i & 3)), "R8 bg palette field");
      check(bgReady === 1'b1, "R2 empty after 8", bgReady, 1);
    end
    palBg = 8'hE4;

    // R7/R8 exhaustive mixer sweep
    for (int c = 0; c < 256; c++) begin
      logic [1:0] b, o, en;
      logic pr, pl;
      b = 2'(c); o = 2'(c >> 2); pr = c[4]; pl = c[5]; en = 2'(c >> 6);
      layerEn = en;
      startLine();
      pushBg({8{b}});
      pushObj({8{o}}, pl, pr);
      shiftExpect(expShade(b, o, pr, pl, en), "R7 selection chain");
    end
    layerEn = 2'b11;

    // R5 merge keeps earlier opaque pixels, fills transparent ones
    rowA = {2'd0, 2'd0, 2'd3, 2'd0, 2'd0, 2'd2, 2'd0, 2'd1};
    rowB = {2'd1, 2'd0, 2'd1, 2'd1, 2'd2, 2'd2, 2'd2, 2'd2};
    startLine();
    pushBg(16'h0000);
    pushObj(rowA, 1'b0, 1'b0);
    pushObj(rowB, 1'b1, 1'b0);
    for (int i = 0; i < 8; i++) begin
      logic [1:0] a, bb;
      a = rowA[2*i +: 2]; bb = rowB[2*i +: 2];
      shiftExpect(a != 0 ? fld(palObj0, a) : (bb != 0 ? fld(palObj1, bb) : fld(palBg, 0)),
                  "R5 object merge");
    end

    // R6 vacated slots are transparent and mergeable
    startLine();
    pushBg(16'h5555);
    pushObj(16'hFFFF, 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) shiftExpect(fld(palObj0, 3), "R6 first object");
    pushObj(16'h5555, 1'b1, 1'b0);
    for (int i = 0; i < 4; i++) shiftExpect(fld(palObj0, 3), "R6 earlier object kept");
    pushBg(16'h5555);
    for (int i = 0; i < 4; i++) shiftExpect(fld(palObj1, 1), "R6 filled slot");
    for (int i = 0; i < 4; i++) shiftExpect(fld(palBg, 1), "R6 transparent fill");

    // R2 push ignored while not empty
    startLine();
    pushBg(16'hE4E4);
    shiftExpect(fld(palBg, 0), "R2 first row");
    shiftExpect(fld(palBg, 1), "R2 first row");
    check(bgReady === 1'b0, "R2 not ready", bgReady, 0);
    pushBg(16'hFFFF);
    for (int i = 2; i < 8; i++) shiftExpect(fld(palBg, 2'(i & 3)), "R2 push ignored");
    dotEn = 1'b1; tick(); dotEn = 1'b0;
    check(shadeValid === 1'b0, "R3 no output when empty", shadeValid, 0);

    // R4 stall and dot enable freeze
    startLine();
    pushBg(16'hE4E4);
    stall = 1'b1; dotEn = 1'b1;
    for (int i = 0; i < 3; i++) begin
      tick();
      check(shadeValid === 1'b0, "R4 stall", shadeValid, 0);
    end
    stall = 1'b0; dotEn = 1'b0;
    tick();
    check(shadeValid === 1'b0, "R4 dotEn low", shadeValid, 0);
    for (int i = 0; i < 8; i++) shiftExpect(fld(palBg, 2'(i & 3)), "R4 resumes in order");

    // R10 object push cycle does not shift
    startLine();
    pushBg(16'hE4E4);
    dotEn = 1'b1;
    pushObj(16'h0000, 1'b0, 1'b0);
    dotEn = 1'b0;
    check(shadeValid === 1'b0, "R10 no shift on merge", shadeValid, 0);
    shiftExpect(fld(palBg, 0), "R10 head unchanged");

    // R9 line limit
    startLine();
    validCount = 0;
    dotEn = 1'b1;
    for (int t = 0; t < 220; t++) begin
      bgPushValid = bgReady;
      bgPlaneLo = 8'hAA; bgPlaneHi = 8'h00;
      tick();
      if (shadeValid) validCount++;
    end
    bgPushValid = 1'b0; dotEn = 1'b0;
    check(validCount == 160, "R9 pixels per line", validCount, 160);
    check(bgReady === 1'b0, "R9 leftover held", bgReady, 0);

    // R1 line start clears
    startLine();
    check(bgReady === 1'b1, "R1 clear ready", bgReady, 1);
    check(shadeValid === 1'b0, "R1 clear valid", shadeValid, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule